// File: doc/BRIEF.md
# Register Renaming Map Unit

This block sits at the front of an out-of-order core and renames one instruction per clock. An incoming instruction names one destination and two source registers by their architectural indices. The block looks up both sources in a map table that points each architectural register at a physical tag. It then hands the destination a fresh physical tag and records that tag in the map. Later readers see the new producer, and no two writers ever share a tag. This removes write-after-write and write-after-read conflicts and keeps read-after-write dependences intact.

Fresh tags come from a counter that starts just above the reset-time identity mapping and only counts up. When the counter has walked past the last tag in the physical space, the block drops its ready output. From then on the map and the counter stay frozen until reset. Freeing tags is left to a later stage of the machine. The renamed instruction is registered, so it appears one clock after it is accepted.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag BASE + i; with the defaults (BASE = 10, four registers) r0..r3 read as tags 10, 11, 12, 13.
- R2: Every accepted instruction with in_has_dst = 1 receives a new destination tag, and its architectural register maps to that tag afterwards. Tags are issued in strictly increasing order starting at BASE + NUM_ARCH (14 with the defaults).
- R3: Source tags are taken from the map as it stood before the same instruction's destination update. An instruction that reads and writes the same register reports the old tag for that source.
- R4: An instruction reading a register written by an earlier accepted instruction reports that producer's destination tag.
- R5: A register that no accepted instruction writes keeps its current mapping.
- R6: An accepted instruction with in_has_dst = 0 has its sources renamed but takes no tag and leaves the map unchanged. Its out_dst_tag reads 0.
- R7: An instruction accepted on one rising edge (in_valid = 1 and in_ready = 1) appears on the output with out_valid = 1 after that edge, with in_op and in_has_dst unchanged. In a cycle with no acceptance, out_valid is 0 after the edge.
- R8: Once the tag after 2^TAG_W - 1 would be needed (the counter reaches 2^TAG_W), in_ready is 0 and stays 0 until reset. Instructions presented then are not accepted: out_valid stays 0 and the map and counter do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present on the input |
| in_ready | output | 1 | Block can accept an instruction (tag space not used up) |
| in_op | input | OP_W | Opcode, passed through unchanged |
| in_has_dst | input | 1 | Instruction writes a destination register |
| in_dst | input | AW | Architectural destination index |
| in_src1 | input | AW | Architectural index of first source |
| in_src2 | input | AW | Architectural index of second source |
| out_valid | output | 1 | Renamed instruction valid |
| out_op | output | OP_W | Opcode of renamed instruction |
| out_has_dst | output | 1 | Renamed instruction writes a destination |
| out_dst_tag | output | TAG_W | New physical destination tag (0 when no destination) |
| out_src1_tag | output | TAG_W | Physical tag of first source |
| out_src2_tag | output | TAG_W | Physical tag of second source |

## Verification
The bench goes after instructions whose destination equals one of their own sources. A design that wrote the map before the lookup would report the new tag there instead of the old one. It also chains writers and readers back to back, where a stale map would hand out an older producer. It mixes in store-like instructions without a destination, which would burn a tag or corrupt an entry if wrongly handled. Finally it runs the counter into the end of the tag space and keeps presenting work. A design that let one more instruction through, or wrapped the counter, would show a valid output or a reused tag there. A reset afterwards must bring back the identity map.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Physical tag held by architectural register idx right after reset.
  function automatic int reset_tag(input int base, input int idx);
    return base + idx;
  endfunction

  // First tag handed out by the allocator.
  function automatic int first_free(input int base, input int narch);
    return base + narch;
  endfunction

  // Counter value meaning that the whole tag space has been spent.
  function automatic int tag_limit(input int tag_w);
    return 1 << tag_w;
  endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = 4,
  parameter int TAG_W    = 5,
  parameter int BASE     = 10,
  localparam int AW = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd1_idx,
  input  logic [AW-1:0]    rd2_idx,
  output logic [TAG_W-1:0] rd1_tag,
  output logic [TAG_W-1:0] rd2_tag,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [TAG_W-1:0] entry [NUM_ARCH];

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry[i] <= TAG_W'(rename_pkg::reset_tag(BASE, i));
      end else if (wr_en && (wr_idx == AW'(i))) begin
        entry[i] <= wr_tag;
      end
    end
  end

  // Reads see the table before this cycle's write lands.
  assign rd1_tag = entry[rd1_idx];
  assign rd2_tag = entry[rd2_idx];

endmodule

// File: rtl/rename_tag_alloc.sv
module rename_tag_alloc #(
  parameter int NUM_ARCH = 4,
  parameter int TAG_W    = 5,
  parameter int BASE     = 10,
  localparam int CW = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [TAG_W-1:0] alloc_tag,
  output logic [CW-1:0]    next_cnt,
  output logic             exhausted
);

  localparam logic [CW-1:0] FIRST = CW'(rename_pkg::first_free(BASE, NUM_ARCH));
  localparam logic [CW-1:0] LIMIT = CW'(rename_pkg::tag_limit(TAG_W));

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= FIRST;
    end else if (take && !exhausted) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign exhausted = (cnt >= LIMIT);
  assign alloc_tag = cnt[TAG_W-1:0];
  assign next_cnt  = cnt;

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH = 4,
  parameter int TAG_W    = 5,
  parameter int BASE     = 10,
  parameter int OP_W     = 4,
  localparam int AW = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_has_dst,
  input  logic [AW-1:0]    in_dst,
  input  logic [AW-1:0]    in_src1,
  input  logic [AW-1:0]    in_src2,
  output logic             out_valid,
  output logic [OP_W-1:0]  out_op,
  output logic             out_has_dst,
  output logic [TAG_W-1:0] out_dst_tag,
  output logic [TAG_W-1:0] out_src1_tag,
  output logic [TAG_W-1:0] out_src2_tag
);

  localparam int CW = TAG_W + 1;

  // Named internal events, observed by the bound checker.
  logic             accept;
  logic             alloc_fire;
  logic             map_wr_en;
  logic             exhausted;
  logic [CW-1:0]    next_cnt;
  logic [TAG_W-1:0] new_tag;
  logic [TAG_W-1:0] src1_tag;
  logic [TAG_W-1:0] src2_tag;

  assign in_ready   = !exhausted;
  assign accept     = in_valid && in_ready;
  assign alloc_fire = accept && in_has_dst;
  assign map_wr_en  = alloc_fire;

  rename_tag_alloc #(
    .NUM_ARCH (NUM_ARCH),
    .TAG_W    (TAG_W),
    .BASE     (BASE)
  ) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (alloc_fire),
    .alloc_tag (new_tag),
    .next_cnt  (next_cnt),
    .exhausted (exhausted)
  );

  rename_map_table #(
    .NUM_ARCH (NUM_ARCH),
    .TAG_W    (TAG_W),
    .BASE     (BASE)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd1_idx (in_src1),
    .rd2_idx (in_src2),
    .rd1_tag (src1_tag),
    .rd2_tag (src2_tag),
    .wr_en   (map_wr_en),
    .wr_idx  (in_dst),
    .wr_tag  (new_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_op       <= '0;
      out_has_dst  <= 1'b0;
      out_dst_tag  <= '0;
      out_src1_tag <= '0;
      out_src2_tag <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_op       <= in_op;
        out_has_dst  <= in_has_dst;
        out_dst_tag  <= in_has_dst ? new_tag : '0;
        out_src1_tag <= src1_tag;
        out_src2_tag <= src2_tag;
      end
    end
  end

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int NUM_ARCH = 4,
  parameter int TAG_W    = 5,
  parameter int BASE     = 10,
  localparam int CW = TAG_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             in_has_dst,
  input logic             accept,
  input logic             alloc_fire,
  input logic             map_wr_en,
  input logic [CW-1:0]    next_cnt,
  input logic             out_valid,
  input logic             out_has_dst,
  input logic [TAG_W-1:0] out_dst_tag
);

  localparam int FIRST = rename_pkg::first_free(BASE, NUM_ARCH);

  initial begin
    assert_fit_R1: assert (FIRST <= rename_pkg::tag_limit(TAG_W))
      else $error("reset mapping does not fit in the tag range");
  end

  assert_accept_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_idle_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);

  assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (next_cnt == $past(next_cnt) + CW'(1)));

  assert_new_tag_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_dst) |-> (int'(out_dst_tag) >= FIRST));

  assert_no_dst_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_has_dst) |=> $stable(next_cnt));

  assert_no_dst_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_en |-> in_has_dst);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (!in_ready && $stable(next_cnt) && !out_valid));

endmodule

bind rename_unit rename_unit_chk #(
  .NUM_ARCH (NUM_ARCH),
  .TAG_W    (TAG_W),
  .BASE     (BASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .in_has_dst  (in_has_dst),
  .accept      (accept),
  .alloc_fire  (alloc_fire),
  .map_wr_en   (map_wr_en),
  .next_cnt    (next_cnt),
  .out_valid   (out_valid),
  .out_has_dst (out_has_dst),
  .out_dst_tag (out_dst_tag)
);

// File: tb/tb_rename_unit.sv
module tb_rename_unit;

  localparam int NA    = 4;
  localparam int TW    = 5;
  localparam int BS    = 10;
  localparam int OW    = 4;
  localparam int AWB   = 2;
  localparam int LIMIT = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [OW-1:0] in_op = '0;
  logic in_has_dst = 1'b0;
  logic [AWB-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic out_valid;
  logic [OW-1:0] out_op;
  logic out_has_dst;
  logic [TW-1:0] out_dst_tag, out_src1_tag, out_src2_tag;

  always #4 clk = ~clk;

  rename_unit #(.NUM_ARCH(NA), .TAG_W(TW), .BASE(BS), .OP_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_has_dst(in_has_dst), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .out_valid(out_valid),
    .out_op(out_op), .out_has_dst(out_has_dst), .out_dst_tag(out_dst_tag),
    .out_src1_tag(out_src1_tag), .out_src2_tag(out_src2_tag)
  );

  // Behavioural reference state.
  int map_q[NA];
  int nxt;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit    exp_valid;
  int    exp_op, exp_hd, exp_d, exp_s1, exp_s2;
  string exp_lbl;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) map_q[i] = BS + i;
    nxt = BS + NA;
    exp_valid = 0;
  endtask

  // Called at a falling edge: compare last cycle's result, then drive the next.
  task automatic step(input bit v, input int op, input bit hd, input int d,
                      input int s1, input int s2, input string lbl);
    chk("R8 in_ready", int'(in_ready), int'(nxt < LIMIT));
    chk("R7 out_valid", int'(out_valid), int'(exp_valid));
    if (exp_valid) begin
      chk("R7 out_op", int'(out_op), exp_op);
      chk("R7 out_has_dst", int'(out_has_dst), exp_hd);
      chk({exp_lbl, " src1"}, int'(out_src1_tag), exp_s1);
      chk({exp_lbl, " src2"}, int'(out_src2_tag), exp_s2);
      chk(exp_hd != 0 ? "R2 dst" : "R6 dst", int'(out_dst_tag), exp_d);
    end
    in_valid   = v;
    in_op      = OW'(op);
    in_has_dst = hd;
    in_dst     = AWB'(d);
    in_src1    = AWB'(s1);
    in_src2    = AWB'(s2);
    exp_valid  = v && (nxt < LIMIT);
    if (exp_valid) begin
      exp_op  = op;
      exp_hd  = hd;
      exp_lbl = lbl;
      exp_s1  = map_q[s1];
      exp_s2  = map_q[s2];
      if (hd) begin
        exp_d = nxt;
        map_q[d] = nxt;
        nxt++;
      end else begin
        exp_d = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk("R7 reset out_valid", int'(out_valid), 0);
    chk("R8 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    // R1: identity map read through store-like instructions (no destination).
    step(1, 9, 0, 0, 0, 1, "R1");
    step(1, 9, 0, 0, 2, 3, "R1");

    // Dependence chain: add r1,r2,r3; sub r3,r2,r1; mul r1,r2,r3; div r2,r1,r3.
    step(1, 1, 1, 1, 2, 3, "R5");
    step(1, 2, 1, 3, 2, 1, "R4");
    step(1, 3, 1, 1, 2, 3, "R4");
    step(1, 4, 1, 2, 1, 3, "R4");

    // R3: destination equals both sources.
    step(1, 5, 1, 0, 0, 0, "R3");
    step(1, 5, 1, 0, 0, 0, "R3");
    // R6: no-destination instruction between writers, then a reader.
    step(1, 7, 0, 3, 3, 0, "R6");
    step(1, 6, 1, 1, 3, 0, "R6");
    // Idle gap (R7) followed by a reader of r2 (R5: unchanged since div).
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(1, 8, 0, 0, 2, 2, "R5");

    // Random stream that runs the tag space dry, then keeps pushing (R8).
    for (int k = 0; k < 40; k++) begin
      step(($urandom_range(0, 9) != 0), int'($urandom_range(0, 15)),
           ($urandom_range(0, 9) < 7), int'($urandom_range(0, NA - 1)),
           int'($urandom_range(0, NA - 1)), int'($urandom_range(0, NA - 1)),
           "R4");
    end
    for (int k = 0; k < 4; k++) step(1, 2, 1, k % NA, 0, 1, "R8");
    chk("R8 stall after exhaustion", int'(in_ready), 0);

    // Reset brings back the identity map and the first free tag.
    step(0, 0, 0, 0, 0, 0, "R8");
    do_reset();
    step(1, 1, 1, 3, 3, 2, "R1");
    step(1, 1, 1, 2, 3, 1, "R2");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");

    finish_run();
  end

endmodule